// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block keeps a dynamic memory usable from reset onward. It decides when refreshes are due. It does not produce the row and column strobe waveforms; the access controller does that. After reset the block holds back for a fixed power-up delay, counted in clock cycles. It then raises a refresh request and keeps it high until a fixed number of refreshes have been acknowledged. Only after that does it declare the memory ready to the host side.

In normal operation an interval timer adds one owed refresh per period. The period is set so that every row is refreshed within the retention time. The default is 3125 cycles at 200 MHz, which is 4096 refreshes in 64 ms. A long-retention setting doubles the period. Each acknowledge from the access controller pays off one owed refresh. The request stays high while any refresh is owed, so a controller holding a page open is pushed to close it. If the debt grows past a set limit, a sticky error flag reports that retention can no longer be relied on.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high, `refresh_req`, `init_done` and `refresh_overflow` are all low. A synchronous reset at any time returns the block to the power-up wait and clears the sticky error.
- R2: After reset is released, `refresh_req` stays low for `PWRUP_CYCLES` clock edges. It rises on the `PWRUP_CYCLES`-th edge, and acknowledges during the wait have no effect.
- R3: After the wait, `refresh_req` stays high until `INIT_REFRESHES` acknowledges have been accepted. `init_done` rises on the edge that accepts the last one, `refresh_req` falls on that same edge, and `init_done` then stays high.
- R4: The interval timer starts on the edge where `init_done` rises. It adds one owed refresh every interval, so the first periodic request appears exactly one interval of edges after `init_done` rises.
- R5: With `LONG_RETENTION` set to 1, the interval is twice `BASE_INTERVAL`.
- R6: The owed count goes up by one on an interval tick and down by one on an accepted acknowledge; when both happen on one edge it is unchanged. `refresh_req` is high exactly when the count is nonzero.
- R7: An acknowledge is accepted only while `refresh_req` is high. Acknowledges while it is low are ignored and do not drive the count below zero.
- R8: `refresh_overflow` is set on the edge where the owed count, after `init_done`, becomes larger than `OWED_LIMIT`. It then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refresh_ack | input | 1 | Access controller has done one refresh cycle |
| refresh_req | output | 1 | At least one refresh is owed |
| init_done | output | 1 | Power-up sequence complete, memory may be used |
| refresh_overflow | output | 1 | Sticky: owed refreshes exceeded the limit |

## Verification
Two instances are built with short delays. One has the base interval and the other the doubled interval. The doubled-interval instance acknowledges on every cycle, so its request lasts a single cycle and the distance between requests shows the doubling directly. The base instance receives acknowledges at chosen cycles:
- An early acknowledge during the power-up wait must not shorten initialization.
- A pause before the last initial acknowledge pins down the edge where `init_done` rises.
- An acknowledge that lands on the same edge as an interval tick must leave the debt unchanged.
- A long run with no acknowledges drives the debt past the limit.
- A final burst with more acknowledges than the debt shows that surplus acknowledges are dropped and that the error flag stays set.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_INIT = 2'd1,
        PH_RUN  = 2'd2
    } drs_phase_e;

    // Bits needed to hold values 0..max_val
    function automatic int drs_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic int drs_max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_cycle_timer.sv
module drs_cycle_timer #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = drs_pkg::drs_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/drs_owed_counter.sv
module drs_owed_counter #(
    parameter int OW    = 4,
    parameter int LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [OW-1:0] load_val,
    input  logic          inc,
    input  logic          dec,
    input  logic          chk_en,
    output logic [OW-1:0] count,
    output logic          over
);
    localparam logic [OW-1:0] TOP = '1;
    localparam logic [OW-1:0] LIM = OW'(LIMIT);

    logic [OW-1:0] count_nxt;

    always_comb begin
        count_nxt = count;
        if (load) begin
            count_nxt = load_val;
        end else begin
            unique case ({inc, dec})
                2'b10:   count_nxt = (count == TOP) ? count : count + 1'b1;
                2'b01:   count_nxt = (count == '0) ? count : count - 1'b1;
                default: count_nxt = count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            over  <= 1'b0;
        end else begin
            count <= count_nxt;
            if (chk_en && (count_nxt > LIM)) begin
                over <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import drs_pkg::*;
#(
    parameter int PWRUP_CYCLES   = 40000,
    parameter int INIT_REFRESHES = 8,
    parameter int BASE_INTERVAL  = 3125,
    parameter bit LONG_RETENTION = 1'b0,
    parameter int OWED_LIMIT     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic refresh_ack,
    output logic refresh_req,
    output logic init_done,
    output logic refresh_overflow
);
    localparam int INTERVAL = LONG_RETENTION ? 2 * BASE_INTERVAL : BASE_INTERVAL;
    localparam int OWED_MAX = drs_max2(INIT_REFRESHES, OWED_LIMIT) + 1;
    localparam int OW       = drs_width(OWED_MAX);

    drs_phase_e    phase;
    logic          pu_tick;
    logic          iv_tick;
    logic          accept;
    logic          owed_over;
    logic [OW-1:0] owed;

    drs_cycle_timer #(.PERIOD(PWRUP_CYCLES)) i_pwrup (
        .clk  (clk),
        .rst  (rst),
        .run  (phase == PH_WAIT),
        .tick (pu_tick)
    );

    drs_cycle_timer #(.PERIOD(INTERVAL)) i_interval (
        .clk  (clk),
        .rst  (rst),
        .run  (phase == PH_RUN),
        .tick (iv_tick)
    );

    drs_owed_counter #(.OW(OW), .LIMIT(OWED_LIMIT)) i_owed (
        .clk      (clk),
        .rst      (rst),
        .load     ((phase == PH_WAIT) && pu_tick),
        .load_val (OW'(INIT_REFRESHES)),
        .inc      (iv_tick),
        .dec      (accept),
        .chk_en   (phase == PH_RUN),
        .count    (owed),
        .over     (owed_over)
    );

    assign refresh_req      = (owed != '0);
    assign accept           = refresh_ack && refresh_req;
    assign init_done        = (phase == PH_RUN);
    assign refresh_overflow = owed_over;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WAIT;
        end else begin
            unique case (phase)
                PH_WAIT: if (pu_tick) phase <= PH_INIT;
                PH_INIT: if (accept && (owed == OW'(1))) phase <= PH_RUN;
                default: phase <= PH_RUN;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       refresh_ack,
    input logic       refresh_req,
    input logic       init_done,
    input logic       refresh_overflow,
    input logic [1:0] phase
);
    // R1: reset clears every output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!refresh_req && !init_done && !refresh_overflow));

    // R2: no request during the power-up wait
    p_wait_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0) |-> !refresh_req);

    // R3: ready only follows an accepted acknowledge, and stays
    p_done_on_ack_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(refresh_ack && refresh_req));
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R6: request can only fall through an acknowledge
    p_req_fall_ack_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(refresh_req) |-> $past(refresh_ack));

    // R8: overflow is sticky and only after ready
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        refresh_overflow |=> refresh_overflow);
    p_ovf_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        refresh_overflow |-> init_done);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk i_chk (
    .clk              (clk),
    .rst              (rst),
    .refresh_ack      (refresh_ack),
    .refresh_req      (refresh_req),
    .init_done        (init_done),
    .refresh_overflow (refresh_overflow),
    .phase            (phase)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;

    localparam int PWRUP = 20;
    localparam int NINIT = 8;
    localparam int IVAL  = 16;
    localparam int LIMIT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ack = 1'b0;
    logic ack_lp = 1'b1;
    logic req, done, ovf;
    logic req_lp, done_lp, ovf_lp;
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    dram_refresh_sched #(
        .PWRUP_CYCLES(PWRUP), .INIT_REFRESHES(NINIT), .BASE_INTERVAL(IVAL),
        .LONG_RETENTION(1'b0), .OWED_LIMIT(LIMIT)
    ) i_dram_refresh_sched (
        .clk(clk), .rst(rst), .refresh_ack(ack),
        .refresh_req(req), .init_done(done), .refresh_overflow(ovf)
    );

    dram_refresh_sched #(
        .PWRUP_CYCLES(PWRUP), .INIT_REFRESHES(NINIT), .BASE_INTERVAL(IVAL),
        .LONG_RETENTION(1'b1), .OWED_LIMIT(LIMIT)
    ) i_dram_refresh_sched_lp (
        .clk(clk), .rst(rst), .refresh_ack(ack_lp),
        .refresh_req(req_lp), .init_done(done_lp), .refresh_overflow(ovf_lp)
    );

    typedef struct {
        int    cyc;
        logic  req;
        logic  done;
        logic  ovf;
        string tag;
    } exp_t;

    exp_t q_main[$];
    exp_t q_lp[$];

    task automatic push_main(int c, logic r, logic d, logic o, string t);
        exp_t e;
        e.cyc = c; e.req = r; e.done = d; e.ovf = o; e.tag = t;
        q_main.push_back(e);
    endtask

    task automatic push_lp(int c, logic r, logic d, logic o, string t);
        exp_t e;
        e.cyc = c; e.req = r; e.done = d; e.ovf = o; e.tag = t;
        q_lp.push_back(e);
    endtask

    task automatic compare(exp_t e, logic r, logic d, logic o, string who);
        n_cmp++;
        if ({r, d, o} !== {e.req, e.done, e.ovf}) begin
            n_bad++;
            $display("FAIL %s %s cyc=%0d actual req/done/ovf=%b%b%b expected=%b%b%b",
                     e.tag, who, e.cyc, r, d, o, e.req, e.done, e.ovf);
        end
    endtask

    // Monitor: pops expectations as their cycle comes up
    always @(negedge clk) begin
        if (!rst) begin
            while (q_main.size() > 0 && q_main[0].cyc == cyc) begin
                compare(q_main[0], req, done, ovf, "base");
                void'(q_main.pop_front());
            end
            while (q_lp.size() > 0 && q_lp[0].cyc == cyc) begin
                compare(q_lp[0], req_lp, done_lp, ovf_lp, "long");
                void'(q_lp.pop_front());
            end
        end
    end

    task automatic wait_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_ack(int c);
        wait_cyc(c);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic direct(logic r, logic d, logic o, string t);
        exp_t e;
        e.cyc = cyc; e.req = 1'b0; e.done = 1'b0; e.ovf = 1'b0; e.tag = t;
        compare(e, r, d, o, "reset");
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        // Expected behaviour of the base instance
        push_main(19,  1'b0, 1'b0, 1'b0, "R2");  // still waiting
        push_main(20,  1'b1, 1'b0, 1'b0, "R2");  // wait over
        push_main(29,  1'b1, 1'b0, 1'b0, "R7");  // early ack did not count
        push_main(31,  1'b1, 1'b0, 1'b0, "R3");
        push_main(32,  1'b0, 1'b1, 1'b0, "R3");  // eighth ack accepted
        push_main(47,  1'b0, 1'b1, 1'b0, "R4");
        push_main(48,  1'b1, 1'b1, 1'b0, "R4");  // first tick
        push_main(51,  1'b0, 1'b1, 1'b0, "R6");
        push_main(64,  1'b1, 1'b1, 1'b0, "R4");
        push_main(80,  1'b1, 1'b1, 1'b0, "R6");  // tick and ack together
        push_main(82,  1'b0, 1'b1, 1'b0, "R6");
        push_main(159, 1'b1, 1'b1, 1'b0, "R8");  // owed = limit
        push_main(160, 1'b1, 1'b1, 1'b1, "R8");  // owed = limit + 1
        push_main(166, 1'b0, 1'b1, 1'b1, "R6");  // debt paid
        push_main(171, 1'b0, 1'b1, 1'b1, "R7");  // surplus acks ignored
        push_main(176, 1'b1, 1'b1, 1'b1, "R8");  // still sticky

        // Expected behaviour of the doubled-interval instance
        push_lp(27, 1'b1, 1'b0, 1'b0, "R3");
        push_lp(28, 1'b0, 1'b1, 1'b0, "R3");
        push_lp(44, 1'b0, 1'b1, 1'b0, "R5");     // base interval: no tick
        push_lp(59, 1'b0, 1'b1, 1'b0, "R5");
        push_lp(60, 1'b1, 1'b1, 1'b0, "R5");     // doubled interval tick
        push_lp(61, 1'b0, 1'b1, 1'b0, "R5");

        // Reset state
        repeat (3) @(negedge clk);
        direct(req, done, ovf, "R1");
        direct(req_lp, done_lp, ovf_lp, "R1");
        rst = 1'b0;

        // Driver
        pulse_ack(5);                               // R7: during wait
        for (int i = 0; i < NINIT - 1; i++) pulse_ack(22 + i);
        pulse_ack(31);
        pulse_ack(50);
        pulse_ack(79);
        pulse_ack(81);
        wait_cyc(161);
        ack = 1'b1;
        wait_cyc(170);
        ack = 1'b0;
        wait_cyc(180);

        // R1: reset mid-run clears sticky error and ready
        rst = 1'b1;
        @(negedge clk);
        direct(req, done, ovf, "R1");
        rst = 1'b0;

        if (q_main.size() != 0 || q_lp.size() != 0) begin
            n_bad++;
            $display("FAIL R1 leftover expectations actual=%0d expected=0",
                     q_main.size() + q_lp.size());
        end
        report();
    end

endmodule